// File: doc/BRIEF.md
# Companded Voice Sample Attenuator

This block scales an 8-bit companded voice sample by one of thirty-two fixed gains and returns the result in the same 8-bit companded form. Each code is a small floating-point number: a sign, a three-bit exponent and a four-bit mantissa, with a bias of 33 folded into the magnitude. A gain stage that handles such codes lets a switching path lower the level of a voice channel without a separate expand and compress stage elsewhere.

Internally the sample is expanded to a 14-bit signed linear value. That value is multiplied by a 14-bit unsigned fractional coefficient taken from a built-in table. The product is then compressed back to 8 bits. The path has two register stages and a fixed latency. There is no back-pressure. A new sample can be offered on every clock, and every offered sample appears at the output two cycles later.

Top module: `mulaw_attenuator`

## Requirements
- R1: An input code holds the sign S in bit 7, the exponent E in bits 6:4 and the mantissa M in bits 3:0, with no bit inversion. It stands for the linear value (1-2S)*((2^E)*(2M+33)-33), so magnitudes run from 0 to 8031 and adjacent codes at E=0 differ by 2.
- R2: The coefficient for gain select k is a Q0.14 fraction. Coefficient 0 is 16383. Each following coefficient is floor(previous*15468/16384), which is about 0.5 dB per step.
- R3: The linear magnitude is multiplied by the selected coefficient and shifted right by 14, which truncates toward zero. The sign of the input is kept.
- R4: The encoder first clips the scaled magnitude m to 8159. It emits the code (E,M) for which (16+M)*2^(E+1) <= m+33 < (17+M)*2^(E+1). Any m+33 that reaches 8192 gives E=7, M=15.
- R5: A result whose scaled magnitude is zero is emitted as 0x00, including results from input 0x80. The code 0x80 never appears on a valid output.
- R6: out_valid equals in_valid from two rising edges earlier. A sample is accepted on every clock where in_valid is high, and no back-pressure exists.
- R7: A synchronous reset clears out_valid and out_code to 0.
- R8: out_code keeps its last value on every cycle where out_valid is low.
- R9: With gain select 0, every input code except 0x80 comes out unchanged.
- R10: The output magnitude field (bits 6:0) never exceeds the input's, and a nonzero output has the input's sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present this cycle |
| in_code | input | 8 | Companded input sample |
| in_gain_sel | input | SEL_W (5) | Attenuation step, 0 = nearly unity |
| out_valid | output | 1 | Output sample present this cycle |
| out_code | output | 8 | Companded attenuated sample |

## Verification
The bench builds the block with its default parameters: a 5-bit gain select that gives 32 coefficients, 14-bit coefficients, and a step multiplier of 15468. With these values every gain step can be reached, and the heaviest step (about -15.5 dB) is deep enough that small nonzero and negative codes collapse to zero. This exposes the negative-zero rule. Full 256-code sweeps at unity and at several steps exercise every exponent band. The stream is also driven with irregular valid gaps, which checks the fixed latency and the hold behaviour.

// File: rtl/mulaw_atten_pkg.sv
package mulaw_atten_pkg;

  localparam int CODE_W   = 8;
  localparam int EXP_W    = 3;
  localparam int MAN_W    = 4;
  localparam int BIAS     = 33;
  localparam int MAG_CLIP = 8159;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;
  } mu_code_t;

  // Coefficient k of a geometric gain ladder, computed at elaboration.
  function automatic int gain_coef(input int idx, input int coef_w, input int step_num);
    longint c;
    c = (longint'(1) << coef_w) - 1;
    for (int k = 1; k <= idx; k++) begin
      c = (c * step_num) >> coef_w;
    end
    return int'(c);
  endfunction

endpackage

// File: rtl/mulaw_expand.sv
module mulaw_expand
  import mulaw_atten_pkg::*;
#(
  parameter int LIN_W = 14
) (
  input  logic [CODE_W-1:0]       code_i,
  output logic signed [LIN_W-1:0] lin_o
);

  mu_code_t         fields;
  logic [5:0]       base;
  logic [LIN_W-1:0] mag;

  always_comb begin
    fields = mu_code_t'(code_i);
    base   = {1'b1, fields.mant, 1'b1};
    mag    = (LIN_W'(base) << fields.expo) - LIN_W'(BIAS);
    lin_o  = fields.sign ? -$signed(mag) : $signed(mag);
  end

endmodule

// File: rtl/gain_table.sv
module gain_table
  import mulaw_atten_pkg::*;
#(
  parameter int SEL_W    = 5,
  parameter int COEF_W   = 14,
  parameter int STEP_NUM = 15468
) (
  input  logic [SEL_W-1:0]  sel_i,
  output logic [COEF_W-1:0] coef_o
);

  localparam int NUM_GAINS = 1 << SEL_W;

  logic [COEF_W-1:0] entries [NUM_GAINS];

  for (genvar g = 0; g < NUM_GAINS; g++) begin : g_entry
    localparam int CVAL = gain_coef(g, COEF_W, STEP_NUM);
    assign entries[g] = COEF_W'(CVAL);
  end

  assign coef_o = entries[sel_i];

endmodule

// File: rtl/scale_mul.sv
module scale_mul #(
  parameter int LIN_W  = 14,
  parameter int COEF_W = 14
) (
  input  logic signed [LIN_W-1:0] lin_i,
  input  logic [COEF_W-1:0]       coef_i,
  output logic signed [LIN_W-1:0] lin_o
);

  localparam int PROD_W = LIN_W + COEF_W;

  logic              neg;
  logic [LIN_W-1:0]  mag;
  logic [PROD_W-1:0] prod;
  logic [LIN_W-1:0]  scaled;

  always_comb begin
    neg    = lin_i[LIN_W-1];
    mag    = neg ? LIN_W'(-lin_i) : LIN_W'(lin_i);
    prod   = PROD_W'(mag) * PROD_W'(coef_i);
    scaled = LIN_W'(prod >> COEF_W);
    lin_o  = neg ? -$signed(scaled) : $signed(scaled);
  end

endmodule

// File: rtl/mulaw_compress.sv
module mulaw_compress
  import mulaw_atten_pkg::*;
#(
  parameter int LIN_W = 14
) (
  input  logic signed [LIN_W-1:0] lin_i,
  output logic [CODE_W-1:0]       code_o
);

  localparam int LOW_LEAD = 5;

  logic             neg;
  logic [LIN_W-1:0] mag;
  logic [LIN_W-1:0] clipped;
  logic [LIN_W-1:0] biased;
  int unsigned      lead_pos;
  mu_code_t         fields;

  always_comb begin
    neg      = lin_i[LIN_W-1];
    mag      = neg ? LIN_W'(-lin_i) : LIN_W'(lin_i);
    clipped  = (mag > LIN_W'(MAG_CLIP)) ? LIN_W'(MAG_CLIP) : mag;
    biased   = clipped + LIN_W'(BIAS);
    lead_pos = LOW_LEAD;
    for (int p = LOW_LEAD + 1; p < LIN_W - 1; p++) begin
      if (biased[p]) lead_pos = p;
    end
    fields.sign = neg;
    if (biased[LIN_W-1]) begin
      fields.expo = '1;
      fields.mant = '1;
    end else begin
      fields.expo = EXP_W'(lead_pos - LOW_LEAD);
      fields.mant = MAN_W'(biased >> (lead_pos - 4));
    end
    code_o = CODE_W'(fields);
  end

endmodule

// File: rtl/mulaw_attenuator.sv
module mulaw_attenuator
  import mulaw_atten_pkg::*;
#(
  parameter int SEL_W    = 5,
  parameter int LIN_W    = 14,
  parameter int COEF_W   = 14,
  parameter int STEP_NUM = 15468
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_code,
  input  logic [SEL_W-1:0] in_gain_sel,
  output logic             out_valid,
  output logic [7:0]       out_code
);

  logic signed [LIN_W-1:0] dec_lin;
  logic [COEF_W-1:0]       sel_coef;
  logic                    s1_valid;
  logic signed [LIN_W-1:0] s1_lin;
  logic [COEF_W-1:0]       s1_coef;
  logic signed [LIN_W-1:0] scaled_lin;
  logic [CODE_W-1:0]       enc_code;

  mulaw_expand #(.LIN_W(LIN_W)) u_expand (
    .code_i (in_code),
    .lin_o  (dec_lin)
  );

  gain_table #(.SEL_W(SEL_W), .COEF_W(COEF_W), .STEP_NUM(STEP_NUM)) u_table (
    .sel_i  (in_gain_sel),
    .coef_o (sel_coef)
  );

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_lin  <= dec_lin;
      s1_coef <= sel_coef;
    end
  end

  scale_mul #(.LIN_W(LIN_W), .COEF_W(COEF_W)) u_mul (
    .lin_i  (s1_lin),
    .coef_i (s1_coef),
    .lin_o  (scaled_lin)
  );

  mulaw_compress #(.LIN_W(LIN_W)) u_compress (
    .lin_i  (scaled_lin),
    .code_o (enc_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_code <= enc_code;
    end
  end

endmodule

// File: rtl/mulaw_attenuator_chk.sv
module mulaw_attenuator_chk #(
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [7:0]       in_code,
  input logic [SEL_W-1:0] in_gain_sel,
  input logic             out_valid,
  input logic [7:0]       out_code
);

  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2) |-> (out_valid == $past(in_valid, 2)));

  p_no_neg_zero_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_code != 8'h80));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 0 && !out_valid) |-> $stable(out_code));

  p_unity_r9: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2 && out_valid && $past(in_gain_sel, 2) == '0 && $past(in_code, 2) != 8'h80)
      |-> (out_code == $past(in_code, 2)));

  p_shrink_r10: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2 && out_valid) |-> (out_code[6:0] <= $past(in_code[6:0], 2)));

  p_sign_r10: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2 && out_valid && out_code != 8'h00) |-> (out_code[7] == $past(in_code[7], 2)));

endmodule

bind mulaw_attenuator mulaw_attenuator_chk #(.SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_code     (in_code),
  .in_gain_sel (in_gain_sel),
  .out_valid   (out_valid),
  .out_code    (out_code)
);

// File: tb/mulaw_attenuator_tb_top.sv
module mulaw_attenuator_tb_top;

  localparam int SEL_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [7:0]       in_code = '0;
  logic [SEL_W-1:0] in_gain_sel = '0;
  logic             out_valid;
  logic [7:0]       out_code;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mulaw_attenuator dut_i (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_code (in_code),
    .in_gain_sel (in_gain_sel), .out_valid (out_valid), .out_code (out_code)
  );

  // ---- independent reference model ----
  function automatic int m_decode(input logic [7:0] c);
    return ((2 * int'(c[3:0]) + 33) << c[6:4]) - 33;
  endfunction

  function automatic int m_coef(input int s);
    int c = 16383;
    for (int k = 0; k < s; k++) c = (c * 15468) / 16384;
    return c;
  endfunction

  function automatic logic [7:0] m_encode(input bit neg, input int mag);
    int m = (mag > 8159) ? 8159 : mag;
    if (m + 33 >= 8192) return {neg, 7'h7F};
    for (int e = 0; e < 8; e++)
      for (int k = 0; k < 16; k++)
        if ((16 + k) * (2 << e) <= m + 33 && m + 33 < (17 + k) * (2 << e))
          return {neg, 3'(e), 4'(k)};
    return 8'hFF;
  endfunction

  function automatic logic [7:0] m_atten(input logic [7:0] c, input int s);
    int scaled = (m_decode(c) * m_coef(s)) / 16384;
    if (scaled == 0) return 8'h00;
    return m_encode(c[7], scaled);
  endfunction

  // ---- checking ----
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  bit         p1_v = 0, p2_v = 0;
  logic [7:0] p1_c = 0, p2_c = 0;
  string      p1_t = "R6", p2_t = "R6";
  logic [7:0] last_code = 0;

  // Drive one cycle at the falling edge; check the item driven two cycles before.
  task automatic step(input bit v, input logic [7:0] c, input int s,
                      input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(out_valid == p2_v, "R6", out_valid, p2_v);
    if (p2_v) begin
      chk(out_code == p2_c, p2_t, out_code, p2_c);
      last_code = p2_c;
    end else begin
      chk(out_code == last_code, "R8", out_code, last_code);
    end
    p2_v = p1_v; p2_c = p1_c; p2_t = p1_t;
    p1_v = v;    p1_c = exp;  p1_t = tag;
    in_valid    = v;
    in_code     = c;
    in_gain_sel = SEL_W'(s);
  endtask

  task automatic flush();
    step(0, 8'h00, 0, 8'h00, "R6");
    step(0, 8'h00, 0, 8'h00, "R6");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", out_valid, 0);
    chk(out_code == 8'h00, "R7", out_code, 0);
    rst = 1'b0;
  endtask

  task automatic t_unity_r9();
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cc = 8'(c);
      step(1, cc, 0, (cc == 8'h80) ? 8'h00 : cc, "R9");
    end
    flush();
  endtask

  task automatic t_ladder_r2();
    for (int s = 0; s < 32; s++) begin
      step(1, 8'h7F, s, m_atten(8'h7F, s), "R2");
      step(1, 8'hF3, s, m_atten(8'hF3, s), "R2");
    end
    flush();
  endtask

  task automatic t_sweep_r3();
    for (int s = 0; s < 32; s += 5)
      for (int c = 0; c < 256; c++)
        step(1, 8'(c), s, m_atten(8'(c), s), "R3");
    flush();
  endtask

  task automatic t_decode_r1();
    // Unity gain on E=0 codes: values 2M, so adjacent codes step by 2.
    step(1, 8'h01, 0, 8'h01, "R1");
    step(1, 8'h02, 0, 8'h02, "R1");
    step(1, 8'h8F, 0, 8'h8F, "R1");
    step(1, 8'h45, 9, m_atten(8'h45, 9), "R1");
    flush();
  endtask

  task automatic t_small_r4();
    for (int s = 20; s < 32; s++)
      for (int c = 0; c < 24; c++)
        step(1, 8'(c), s, m_atten(8'(c), s), "R4");
    flush();
  endtask

  task automatic t_zero_r5();
    for (int s = 0; s < 32; s += 3) step(1, 8'h80, s, 8'h00, "R5");
    step(1, 8'h81, 31, m_atten(8'h81, 31), "R5");
    step(1, 8'h81, 31, 8'h00, "R5");
    step(1, 8'h00, 17, 8'h00, "R5");
    flush();
  endtask

  task automatic t_gaps_r8();
    for (int i = 0; i < 60; i++) begin
      bit v = ((i % 3) == 0) || ((i % 7) == 2);
      logic [7:0] c = 8'(i * 37 + 11);
      step(v, c, i % 32, m_atten(c, i % 32), "R8");
    end
    flush();
  endtask

  task automatic t_sign_r10();
    for (int c = 1; c < 128; c += 9) begin
      step(1, 8'(c), 12, m_atten(8'(c), 12), "R10");
      step(1, 8'(c) | 8'h80, 12, m_atten(8'(c) | 8'h80, 12), "R10");
    end
    flush();
  endtask

  task automatic t_midreset_r7();
    step(1, 8'h55, 0, 8'h55, "R7");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", out_valid, 0);
    chk(out_code == 8'h00, "R7", out_code, 0);
    rst = 1'b0;
    in_valid = 1'b0;
    p1_v = 0; p2_v = 0; last_code = 0;
    flush();
  endtask

  initial begin
    t_reset();
    t_unity_r9();
    t_decode_r1();
    t_ladder_r2();
    t_sweep_r3();
    t_small_r4();
    t_zero_r5();
    t_gaps_r8();
    t_sign_r10();
    t_midreset_r7();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule